// File: doc/BRIEF.md
# SDRAM Command Sequencing Monitor

This block watches the command pins of a four-bank synchronous DRAM, one command per clock, and checks each command against the sequencing rules of the device. It follows each bank through three conditions: closed, open (row active), and bursting with self-closing (auto-precharge). It also tracks the one column burst in flight and a recovery window per bank. A command that breaks a rule gives a one-cycle error pulse and a reason code. The block never changes its own view of the banks on a rejected command.

Alongside the rule checks it produces two byte-mask views of the data bus. One is the write byte enable, which follows the mask pin in the same cycle during a write data phase. The other is a registered read output enable, which follows the mask pin two edges later. The block is a passive monitor placed beside a memory controller or a memory model. It has no stream interface and applies no back-pressure. Every pin is plain control or status, sampled on each rising clock edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is taken only when `clk_en` was high at the previous edge and `sel_n` is low. The code {row_n,col_n,wr_n} maps as follows: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no operation. A deselect, a no-operation, or any command taken while the previous enable was low raises no error.
- R2: A mode set while any bank is open, bursting or still recovering raises code 1.
- R3: During the two edges after an accepted mode set, any command other than no-operation or deselect raises code 2 and is ignored.
- R4: A refresh raises code 3 if any bank is open, bursting or recovering. This covers both auto refresh (`clk_en` high) and self-refresh entry (`clk_en` low at the command edge).
- R5: `bank_sel` values 0..3 select banks A..D. A precharge with `ap_bit` high closes every open bank and ignores `bank_sel`. With `ap_bit` low it closes only the selected bank. Each bank it closes enters a recovery of T_RP edges.
- R6: A read or write issued with `ap_bit` high starts a self-closing burst. Any read or write on the BURST_LEN-1 edges that follow raises code 6, and an activate to that bank raises code 5.
- R7: An activate to a bank in recovery raises code 7. A bank that closed itself at the last burst edge e may be activated from edge e+T_RP.
- R8: A read or write to a bank that is not open raises code 4. An activate to a bank that is open or bursting raises code 5.
- R9: A burst stop ends the current burst at its own edge. If the burst was self-closing, the bank closes there and its recovery counts from that edge.
- R10: `wr_byte_en` equals NOT `byte_mask` in the same cycle during a write data phase and is low otherwise. A write data phase is the accepted write edge plus the following BURST_LEN-1 edges, cut short by an accepted burst stop or a new accepted column command.
- R11: `rd_out_en` after edge n+1 equals NOT `byte_mask` sampled at edge n, so it applies at edge n+2. It is low from reset until then.
- R12: `err_pulse` is high for the single cycle after the offending edge, with `err_code` holding the reason. `err_code` is 0 whenever `err_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock-enable pin of the memory |
| sel_n | input | 1 | Chip select, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bank_sel | input | 2 | Bank address |
| ap_bit | input | 1 | Auto-precharge / all-banks address bit |
| byte_mask | input | 1 | Data mask pin |
| err_pulse | output | 1 | One-cycle rule-violation flag |
| err_code | output | 3 | Violation reason, 0 when none |
| wr_byte_en | output | 1 | Write byte enable, zero latency |
| rd_out_en | output | 1 | Read output enable, mask latency two |

## Verification
The bench builds the monitor with BURST_LEN=4, T_RP=3, a two-edge mode-set gap and a two-edge read mask latency. A four-edge burst leaves three edges in which a second column command collides with a self-closing burst. It also leaves room to cut a burst short with a stop. A three-edge recovery leaves two edges in which an early activate is rejected before the first legal one. The mask pin is driven from a shift-register pattern throughout, so the same-cycle write enable and the two-edge read enable see many mixed sequences.

// File: rtl/sdcmon_pkg.sv
package sdcmon_pkg;
  localparam int BANK_W = 2;

  typedef enum logic [2:0] {
    OP_MODE = 3'b000,
    OP_REFR = 3'b001,
    OP_PRE  = 3'b010,
    OP_ACT  = 3'b011,
    OP_WR   = 3'b100,
    OP_RD   = 3'b101,
    OP_STOP = 3'b110,
    OP_NOP  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_MODE_BUSY = 3'd1,
    ERR_MODE_GAP  = 3'd2,
    ERR_REFR_BUSY = 3'd3,
    ERR_RW_CLOSED = 3'd4,
    ERR_ACT_OPEN  = 3'd5,
    ERR_AP_BUSY   = 3'd6,
    ERR_ACT_RECOV = 3'd7
  } err_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_APB  = 2'd2
  } bank_st_e;

  typedef struct packed {
    logic              live;
    op_e               op;
    logic [BANK_W-1:0] bank;
    logic              ap;
  } cmd_t;
endpackage

// File: rtl/sdcmon_decode.sv
module sdcmon_decode
  import sdcmon_pkg::*;
(
  input  logic              cke_prev,
  input  logic              sel_n,
  input  logic              row_n,
  input  logic              col_n,
  input  logic              wr_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ap_bit,
  output cmd_t              cmd
);
  op_e op;

  always_comb begin
    op       = op_e'({row_n, col_n, wr_n});
    cmd.op   = op;
    cmd.bank = bank_sel;
    cmd.ap   = ap_bit;
    cmd.live = cke_prev & ~sel_n & (op != OP_NOP);
  end
endmodule

// File: rtl/sdcmon_bank.sv
module sdcmon_bank
  import sdcmon_pkg::*;
#(
  parameter int T_RP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic open_ap_i,
  input  logic close_i,
  output logic is_open,
  output logic is_apb,
  output logic in_recov
);
  localparam int REC_W = $clog2(T_RP + 1);

  bank_st_e         st;
  logic [REC_W-1:0] rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      rec <= '0;
    end else if (close_i) begin
      st  <= BK_IDLE;
      rec <= REC_W'(T_RP - 1);
    end else begin
      if (open_ap_i)  st <= BK_APB;
      else if (act_i) st <= BK_OPEN;
      if (rec != '0) rec <= rec - 1'b1;
    end
  end

  assign is_open  = (st == BK_OPEN);
  assign is_apb   = (st == BK_APB);
  assign in_recov = (rec != '0);
endmodule

// File: rtl/sdcmon_dly.sv
module sdcmon_dly #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sh;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = sh[DEPTH-1];
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdcmon_pkg::*;
#(
  parameter int BURST_LEN   = 4,
  parameter int T_RP        = 3,
  parameter int MODE_GAP    = 2,
  parameter int RD_MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel_n,
  input  logic              row_n,
  input  logic              col_n,
  input  logic              wr_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ap_bit,
  input  logic              byte_mask,
  output logic              err_pulse,
  output logic [2:0]        err_code,
  output logic              wr_byte_en,
  output logic              rd_out_en
);
  localparam int BANKS = 1 << BANK_W;
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam int GAP_W = $clog2(MODE_GAP + 1);

  // previous-edge clock enable
  logic cke_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= clk_en;
  end

  cmd_t cmd;
  sdcmon_decode u_dec (
    .cke_prev (cke_q),
    .sel_n    (sel_n),
    .row_n    (row_n),
    .col_n    (col_n),
    .wr_n     (wr_n),
    .bank_sel (bank_sel),
    .ap_bit   (ap_bit),
    .cmd      (cmd)
  );

  logic [BANKS-1:0] bk_open, bk_apb, bk_rec;
  logic [BANKS-1:0] bk_act, bk_open_ap, bk_close;

  // shared burst tracker
  logic [CNT_W-1:0]  rem;
  logic [BANK_W-1:0] b_bank;
  logic              b_ap, b_wr;
  logic [GAP_W-1:0]  gap_cnt;

  logic all_quiet, gap_busy, ap_run;
  err_e code;
  logic ok, live_cmd;
  logic mode_ok, col_ok, act_ok, pre_ok, stop_ok, pre_all_ok, ap_end;

  assign all_quiet = ~|(bk_open | bk_apb | bk_rec);
  assign gap_busy  = (gap_cnt != '0);
  assign ap_run    = (rem != '0) & b_ap;
  assign live_cmd  = cmd.live;

  always_comb begin
    code = ERR_NONE;
    if (cmd.live) begin
      if (gap_busy) begin
        code = ERR_MODE_GAP;
      end else begin
        case (cmd.op)
          OP_MODE: if (!all_quiet) code = ERR_MODE_BUSY;
          OP_REFR: if (!all_quiet) code = ERR_REFR_BUSY;
          OP_ACT: begin
            if (bk_open[cmd.bank] | bk_apb[cmd.bank]) code = ERR_ACT_OPEN;
            else if (bk_rec[cmd.bank])                code = ERR_ACT_RECOV;
          end
          OP_RD, OP_WR: begin
            if (ap_run)                  code = ERR_AP_BUSY;
            else if (!bk_open[cmd.bank]) code = ERR_RW_CLOSED;
          end
          default: code = ERR_NONE;
        endcase
      end
    end
  end

  assign ok         = cmd.live & (code == ERR_NONE);
  assign mode_ok    = ok & (cmd.op == OP_MODE);
  assign col_ok     = ok & ((cmd.op == OP_RD) | (cmd.op == OP_WR));
  assign act_ok     = ok & (cmd.op == OP_ACT);
  assign pre_ok     = ok & (cmd.op == OP_PRE);
  assign stop_ok    = ok & (cmd.op == OP_STOP);
  assign pre_all_ok = pre_ok & cmd.ap;
  assign ap_end     = ap_run & (stop_ok | (rem == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      b_bank <= '0;
      b_ap   <= 1'b0;
      b_wr   <= 1'b0;
    end else if (col_ok) begin
      rem    <= CNT_W'(BURST_LEN - 1);
      b_bank <= cmd.bank;
      b_ap   <= cmd.ap;
      b_wr   <= (cmd.op == OP_WR);
    end else if (stop_ok) begin
      rem    <= '0;
    end else if (rem != '0) begin
      rem    <= rem - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap_cnt <= '0;
    else if (mode_ok)       gap_cnt <= GAP_W'(MODE_GAP);
    else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
  end

  generate
    for (genvar i = 0; i < BANKS; i++) begin : g_bank
      logic hit;
      assign hit           = (cmd.bank == BANK_W'(i));
      assign bk_act[i]     = act_ok & hit;
      assign bk_open_ap[i] = col_ok & cmd.ap & hit;
      assign bk_close[i]   = (pre_ok & (cmd.ap | hit) & bk_open[i])
                           | (ap_end & (b_bank == BANK_W'(i)))
                           | (col_ok & cmd.ap & (BURST_LEN == 1) & hit);

      sdcmon_bank #(.T_RP(T_RP)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (bk_act[i]),
        .open_ap_i (bk_open_ap[i]),
        .close_i   (bk_close[i]),
        .is_open   (bk_open[i]),
        .is_apb    (bk_apb[i]),
        .in_recov  (bk_rec[i])
      );
    end
  endgenerate

  // error pulse
  err_e err_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      err_pulse <= (code != ERR_NONE);
      err_q     <= code;
    end
  end
  assign err_code = err_q;

  // byte masks
  logic wr_phase;
  assign wr_phase   = col_ok ? (cmd.op == OP_WR)
                             : (~stop_ok & (rem != '0) & b_wr);
  assign wr_byte_en = wr_phase & ~byte_mask;

  sdcmon_dly #(.DEPTH(RD_MASK_LAT)) u_rdmask (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (~byte_mask),
    .dout  (rd_out_en)
  );
endmodule

// File: rtl/sdcmon_checker.sv
module sdcmon_checker #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_mask,
  input logic          rd_out_en,
  input logic          wr_byte_en,
  input logic          err_pulse,
  input logic [2:0]    err_code,
  input logic          mode_ok,
  input logic          live_cmd,
  input logic          pre_all_ok,
  input logic [NB-1:0] bk_open,
  input logic [NB-1:0] bk_apb
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  p_rd_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (rd_out_en == !$past(byte_mask, 2)));

  p_wr_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_en |-> !byte_mask);

  p_quiet_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_code == 3'd0));

  p_mode_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && $past(mode_ok) && live_cmd) |=> (err_pulse && err_code == 3'd2));

  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_ok |=> (bk_open == '0));

  p_ap_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bk_apb));
endmodule

bind sdram_cmd_monitor sdcmon_checker #(.NB(4)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_mask  (byte_mask),
  .rd_out_en  (rd_out_en),
  .wr_byte_en (wr_byte_en),
  .err_pulse  (err_pulse),
  .err_code   (err_code),
  .mode_ok    (mode_ok),
  .live_cmd   (live_cmd),
  .pre_all_ok (pre_all_ok),
  .bk_open    (bk_open),
  .bk_apb     (bk_apb)
);

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;
  localparam int BL  = 4;
  localparam int TRP = 3;
  localparam int NB  = 4;
  localparam bit [2:0] MODE = 3'b000, REFR = 3'b001, PRE = 3'b010, ACT = 3'b011,
                       WR = 3'b100, RD = 3'b101, STOP = 3'b110, NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1, sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
  logic [1:0] bank_sel = '0;
  logic ap_bit = 1'b0, byte_mask = 1'b0;
  logic err_pulse, wr_byte_en, rd_out_en;
  logic [2:0] err_code;

  always #4 clk = ~clk;

  sdram_cmd_monitor #(.BURST_LEN(BL), .T_RP(TRP), .MODE_GAP(2), .RD_MASK_LAT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n), .row_n(row_n),
    .col_n(col_n), .wr_n(wr_n), .bank_sel(bank_sel), .ap_bit(ap_bit),
    .byte_mask(byte_mask), .err_pulse(err_pulse), .err_code(err_code),
    .wr_byte_en(wr_byte_en), .rd_out_en(rd_out_en)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state, kept as times of events
  int t = 0;
  bit prev_cke = 0;
  bit open_m[NB];
  int ready_at[NB];
  bit ap_flag = 0;
  int ap_bank = 0;
  int burst_last = -100;
  bit burst_wr = 0;
  int mode_at = -100;
  bit mask_q[$];
  bit [7:0] lf = 8'hA5;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic step(string tag, bit ce, bit sn, bit [2:0] op, int bk, bit ap);
    bit dm, live, apb_any, quiet, ok, wrp, exp_rd;
    int code;
    dm = lf[0];
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    clk_en = ce; sel_n = sn; {row_n, col_n, wr_n} = op;
    bank_sel = bk[1:0]; ap_bit = ap; byte_mask = dm;

    live    = prev_cke && !sn && (op != NOP);
    apb_any = ap_flag && (t <= burst_last);
    quiet   = 1;
    for (int b = 0; b < NB; b++)
      if (open_m[b] || t < ready_at[b] || (apb_any && ap_bank == b)) quiet = 0;

    code = 0;
    if (live) begin
      if (t - mode_at >= 1 && t - mode_at <= 2) code = 2;
      else case (op)
        MODE: if (!quiet) code = 1;
        REFR: if (!quiet) code = 3;
        ACT: begin
          if (open_m[bk] || (apb_any && ap_bank == bk)) code = 5;
          else if (t < ready_at[bk]) code = 7;
        end
        RD, WR: begin
          if (apb_any) code = 6;
          else if (!open_m[bk]) code = 4;
        end
        default: code = 0;
      endcase
    end
    ok = live && (code == 0);

    if (ok && (op == RD || op == WR)) wrp = (op == WR);
    else if (ok && op == STOP)        wrp = 0;
    else                              wrp = (t <= burst_last) && burst_wr;

    if (ok) begin
      case (op)
        MODE: mode_at = t;
        PRE: for (int b = 0; b < NB; b++)
               if ((ap || b == bk) && open_m[b]) begin open_m[b] = 0; ready_at[b] = t + TRP; end
        ACT: open_m[bk] = 1;
        RD, WR: begin
          burst_last = t + BL - 1; burst_wr = (op == WR);
          ap_flag = ap; ap_bank = bk;
          if (ap) begin open_m[bk] = 0; ready_at[bk] = burst_last + TRP; end
        end
        STOP: if (t <= burst_last) begin
          if (ap_flag) ready_at[ap_bank] = t + TRP;
          burst_last = t - 1;
        end
        default: ;
      endcase
    end

    exp_rd = mask_q.pop_front();
    mask_q.push_back(!dm);
    prev_cke = ce;
    t++;

    #1;
    chk(tag, "wr_byte_en", wr_byte_en, int'(wrp && !dm));
    @(posedge clk);
    @(negedge clk);
    chk(tag, "err_pulse", err_pulse, int'(code != 0));
    chk(tag, "err_code", err_code, code);
    chk(tag, "rd_out_en", rd_out_en, int'(exp_rd));
  endtask

  task automatic cmd(string tag, bit [2:0] op, int bk, bit ap);
    step(tag, 1'b1, 1'b0, op, bk, ap);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin open_m[b] = 0; ready_at[b] = 0; end
    mask_q.push_back(1'b0);
    repeat (3) @(negedge clk);
    chk("R12", "err_pulse in reset", err_pulse, 0);
    chk("R11", "rd_out_en in reset", rd_out_en, 0);
    rst_n = 1'b1;

    // R1: idle bus, first edge has no previous enable
    cmd("R1", NOP, 0, 0);
    cmd("R1", NOP, 0, 0);
    // R2/R3: legal mode set, then gap
    cmd("R2", MODE, 0, 0);
    cmd("R3", ACT, 0, 0);
    cmd("R3", NOP, 0, 0);
    cmd("R3", ACT, 0, 0);
    // R2/R4: busy device
    cmd("R2", MODE, 0, 0);
    cmd("R4", REFR, 0, 0);
    step("R4", 1'b0, 1'b0, REFR, 0, 0);
    // R1: previous enable low, command ignored; deselect ignored
    step("R1", 1'b1, 1'b0, RD, 2, 0);
    step("R1", 1'b1, 1'b1, RD, 2, 0);
    // R8: closed bank access, double activate
    cmd("R8", RD, 1, 0);
    cmd("R8", ACT, 0, 0);
    // R10/R9: write burst, stop, interrupted read
    cmd("R10", ACT, 1, 0);
    cmd("R10", WR, 1, 0);
    cmd("R10", NOP, 0, 0);
    cmd("R10", NOP, 0, 0);
    cmd("R9", STOP, 0, 0);
    cmd("R10", NOP, 0, 0);
    cmd("R10", RD, 1, 0);
    cmd("R10", WR, 1, 0);
    for (int k = 0; k < 5; k++) cmd("R10", NOP, 0, 0);
    // R6/R7: self-closing read on bank A
    cmd("R6", RD, 0, 1);
    cmd("R6", RD, 1, 0);
    cmd("R6", ACT, 0, 0);
    cmd("R6", WR, 0, 0);
    cmd("R6", RD, 1, 0);
    cmd("R7", ACT, 0, 0);
    cmd("R7", ACT, 0, 0);
    // R5: single and all-bank precharge
    cmd("R5", PRE, 1, 0);
    cmd("R5", RD, 0, 0);
    cmd("R5", RD, 1, 0);
    cmd("R5", PRE, 1, 1);
    cmd("R5", RD, 0, 0);
    cmd("R5", ACT, 0, 0);
    cmd("R5", ACT, 0, 0);
    // R9: stop a self-closing write on bank D
    cmd("R9", ACT, 3, 0);
    cmd("R9", WR, 3, 1);
    cmd("R9", STOP, 0, 0);
    cmd("R9", RD, 0, 0);
    cmd("R7", ACT, 3, 0);
    cmd("R7", ACT, 3, 0);
    // R2/R3/R4: quiet device, mode set, gap, refresh
    cmd("R5", PRE, 0, 1);
    for (int k = 0; k < 4; k++) cmd("R2", NOP, 0, 0);
    cmd("R2", MODE, 0, 0);
    cmd("R3", NOP, 0, 0);
    cmd("R3", MODE, 0, 0);
    cmd("R4", REFR, 0, 0);
    for (int k = 0; k < 4; k++) cmd("R11", NOP, 0, 0);

    summary();
    $finish;
  end
endmodule